// File: doc/BRIEF.md
# Audio clock ratio and speed-mode detector

This block watches an audio master clock and the frame clock that marks each sample period. It reports the integer ratio between the two and the speed class of the stream: single, double or quad rate. Everything runs in the master clock domain. The frame clock and a fixed-frequency reference clock are both brought in through two-flop synchronizers.

Two counts feed the decision. The first is the number of master clock cycles between consecutive rising edges of the frame clock, which is matched against the set of legal ratios. The second is the number of master clock cycles across a fixed window of reference clock edges, which measures the absolute master clock frequency. Some ratios are legal in two speed classes, and the second count settles which one applies. The detector reports a combination it cannot accept with a flag rather than locking onto it. It asserts lock only once the classification has repeated.

Top module: `audio_rate_detect`

## Requirements
- R1: While reset is held, and on the first clock after it, `ratio_code`, `speed_mode`, `locked`, `ratio_err` and `unsupported` are all zero.
- R2: A frame period is the number of master clock cycles between two rising edges of the synchronized frame clock. A period within ±TOL cycles of a legal ratio selects that ratio's index. The indices are 0:64, 1:96, 2:128, 3:192, 4:256, 5:384, 6:512, 7:768, 8:1024, 9:1152.
- R3: A frame period that matches no ratio within ±TOL sets `ratio_err` to 1 and clears both `locked` and `unsupported`.
- R4: `speed_mode` is 0 for single, 1 for double and 2 for quad rate, and never 3. Let M be the master clock cycles counted over REF_WINDOW reference rising edges and R the matched ratio. The mode is quad if M ≥ R·FRAMES_DQ, double if M ≥ R·FRAMES_SD, and single otherwise.
- R5: Ratio 256 is reported as single or double rate according to the absolute count M alone.
- R6: Ratio 128 is reported as double or quad rate according to the absolute count M alone.
- R7: A matched ratio that is not legal in the selected mode sets `unsupported` to 1 and keeps `locked` at 0 and `ratio_err` at 0. The legal sets are: single indices 4 to 9, double indices 2 to 6, quad indices 0 to 4.
- R8: An absolute count M above MCLK_MAX sets `unsupported` to 1 and keeps `locked` at 0.
- R9: `locked` rises when two consecutive frame periods give the same supported ratio and mode. The codes do not change while `locked` stays high.
- R10: `locked` falls on the first frame period that classifies differently from the locked result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mclk | input | 1 | Master clock; all logic and outputs run on it |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Frame clock at the sample rate, synchronous to the master clock |
| ref_clk | input | 1 | Fixed-frequency reference clock, slower than half the master clock |
| ratio_code | output | 4 | Index of the matched ratio |
| speed_mode | output | 2 | Speed class: 0 single, 1 double, 2 quad |
| locked | output | 1 | Classification stable and supported |
| ratio_err | output | 1 | Last frame period matched no legal ratio |
| unsupported | output | 1 | Ratio matched but its combination with the frequency is not accepted |

## Verification
The bench shrinks the block to REF_WINDOW=8, FRAMES_SD=2, FRAMES_DQ=4, MCLK_MAX=1500 and a 12-bit count, with TOL left at 2. With these values a reference window lasts only a few frame periods, so a change of reference period moves the absolute count across both mode thresholds and past the frequency ceiling within a few thousand cycles. This brings within reach: both ambiguous ratios in each of their modes, a ratio illegal in its mode, an over-frequency case, the ±2 tolerance edges, and a lock drop with relock.

// File: rtl/ard_pkg.sv
// Shared types and constant tables for the audio clock ratio detector.
// Assumes the legal ratio set is fixed at ten entries in ascending order.
package ard_pkg;

    localparam int NUM_RATIOS = 10;
    localparam int IDX_W      = 4;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    // Master-clock cycles per frame for each ratio index.
    function automatic int ratio_of(input int idx);
        case (idx)
            0: return 64;
            1: return 96;
            2: return 128;
            3: return 192;
            4: return 256;
            5: return 384;
            6: return 512;
            7: return 768;
            8: return 1024;
            default: return 1152;
        endcase
    endfunction

    // Whether a ratio index is legal in a given speed class.
    function automatic logic mode_allows(input speed_e m, input int idx);
        case (m)
            SPD_SINGLE: return (idx >= 4);
            SPD_DOUBLE: return (idx >= 2) && (idx <= 6);
            default:    return (idx <= 4);
        endcase
    endfunction

endpackage

// File: rtl/ard_sync_rise.sv
// Two-flop synchronizer with a rising-edge pulse on the synchronized signal.
// Assumes the input toggles slower than half the sampling clock.
module ard_sync_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] stage;

    // Shift the input through two sync flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], din};
    end

    assign rise = stage[1] & ~stage[2];
endmodule

// File: rtl/ard_span_counter.sv
// Counts sampling-clock cycles spanned by SPAN consecutive rise pulses.
// The first rise after reset only arms the counter, so no partial span is
// reported. The count saturates at its all-ones value.
module ard_span_counter #(
    parameter int CNT_W = 16,
    parameter int SPAN  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] span_cnt,
    output logic             done,
    output logic             valid
);
    localparam int K_W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [K_W-1:0]   K_LAST = K_W'(SPAN - 1);
    localparam logic [CNT_W-1:0] SAT    = '1;

    logic             armed;
    logic [K_W-1:0]   k;
    logic [CNT_W-1:0] run;
    logic [CNT_W-1:0] run_inc;

    assign run_inc = (run == SAT) ? run : run + 1'b1;

    // Track rises in the current span and capture its length on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            k        <= '0;
            run      <= '0;
            span_cnt <= '0;
            done     <= 1'b0;
            valid    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rise && !armed) begin
                armed <= 1'b1;
                k     <= '0;
                run   <= CNT_W'(1);
            end else if (rise && k == K_LAST) begin
                span_cnt <= run;
                done     <= 1'b1;
                valid    <= 1'b1;
                k        <= '0;
                run      <= CNT_W'(1);
            end else if (rise) begin
                k   <= k + 1'b1;
                run <= run_inc;
            end else begin
                run <= run_inc;
            end
        end
    end

    // R2: once a span has been measured the result stays valid
    a_r2_span_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    // R2: a completed span is always triggered by a rise pulse
    a_r2_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rise));
endmodule

// File: rtl/ard_classify.sv
// Combinational classifier: matches a frame period against the legal ratios
// and picks the speed class from the absolute master-clock count.
// Assumes TOL is small enough that at most one ratio matches.
module ard_classify
    import ard_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TOL       = 2,
    parameter int FRAMES_SD = 19,
    parameter int FRAMES_DQ = 38,
    parameter int MCLK_MAX  = 17000
) (
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] meas,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output speed_e           mode,
    output logic             supported
);
    logic [NUM_RATIOS-1:0] hits;

    // One tolerance window comparator per legal ratio.
    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_match
        localparam int RATIO = ratio_of(g);
        assign hits[g] = (int'(period) + TOL >= RATIO) && (int'(period) <= RATIO + TOL);
    end

    // Encode the matching ratio and derive mode and support from it.
    always_comb begin
        int sel_ratio;
        int m;
        idx = '0;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hits[i]) idx = IDX_W'(i);
        end
        hit       = |hits;
        sel_ratio = ratio_of(int'(idx));
        m         = int'(meas);
        if (m >= sel_ratio * FRAMES_DQ)      mode = SPD_QUAD;
        else if (m >= sel_ratio * FRAMES_SD) mode = SPD_DOUBLE;
        else                                 mode = SPD_SINGLE;
        supported = hit && mode_allows(mode, int'(idx)) && (m <= MCLK_MAX);
    end
endmodule

// File: rtl/audio_rate_detect.sv
// Audio clock ratio and speed-mode detector, master clock domain.
// Assumes the frame clock is synchronous to the master clock and the
// reference clock runs below half the master clock frequency.
module audio_rate_detect
    import ard_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int REF_WINDOW = 4096,
    parameter int TOL        = 2,
    parameter int FRAMES_SD  = 19,
    parameter int FRAMES_DQ  = 38,
    parameter int MCLK_MAX   = 17000
) (
    input  logic       clk_mclk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       ref_clk,
    output logic [3:0] ratio_code,
    output logic [1:0] speed_mode,
    output logic       locked,
    output logic       ratio_err,
    output logic       unsupported
);
    localparam int CLS_W = IDX_W + 2;

    logic             frame_rise, ref_rise;
    logic [CNT_W-1:0] period, meas;
    logic             period_done, period_ok, meas_done, meas_ok;
    logic             hit, supported;
    logic [IDX_W-1:0] idx;
    speed_e           mode;
    logic [CLS_W-1:0] cur_cls, prev_cls;
    logic             prev_ok;

    ard_sync_rise u_frame_sync (.clk(clk_mclk), .rst_n(rst_n), .din(frame_clk), .rise(frame_rise));
    ard_sync_rise u_ref_sync   (.clk(clk_mclk), .rst_n(rst_n), .din(ref_clk),   .rise(ref_rise));

    ard_span_counter #(.CNT_W(CNT_W), .SPAN(1)) u_period (
        .clk(clk_mclk), .rst_n(rst_n), .rise(frame_rise),
        .span_cnt(period), .done(period_done), .valid(period_ok));

    ard_span_counter #(.CNT_W(CNT_W), .SPAN(REF_WINDOW)) u_window (
        .clk(clk_mclk), .rst_n(rst_n), .rise(ref_rise),
        .span_cnt(meas), .done(meas_done), .valid(meas_ok));

    ard_classify #(.CNT_W(CNT_W), .TOL(TOL), .FRAMES_SD(FRAMES_SD),
                   .FRAMES_DQ(FRAMES_DQ), .MCLK_MAX(MCLK_MAX)) u_cls (
        .period(period), .meas(meas), .hit(hit), .idx(idx),
        .mode(mode), .supported(supported));

    assign cur_cls = {idx, mode};

    // Update flags and codes once per frame period, filtering lock over two periods.
    always_ff @(posedge clk_mclk) begin
        if (!rst_n) begin
            ratio_code  <= '0;
            speed_mode  <= '0;
            locked      <= 1'b0;
            ratio_err   <= 1'b0;
            unsupported <= 1'b0;
            prev_cls    <= '0;
            prev_ok     <= 1'b0;
        end else if (period_done && period_ok && meas_ok && !meas_done) begin
            if (!hit) begin
                ratio_err   <= 1'b1;
                unsupported <= 1'b0;
                locked      <= 1'b0;
                prev_ok     <= 1'b0;
            end else begin
                ratio_err   <= 1'b0;
                unsupported <= !supported;
                ratio_code  <= idx;
                speed_mode  <= mode;
                locked      <= supported && prev_ok && (cur_cls == prev_cls);
                prev_cls    <= cur_cls;
                prev_ok     <= supported;
            end
        end
    end

    // R3 R7: lock never coexists with either fault flag
    a_r3_lock_clears_flags: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        locked |-> (!ratio_err && !unsupported));

    // R7: the two fault flags are mutually exclusive
    a_r7_flags_exclusive: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        !(ratio_err && unsupported));

    // R4: the speed code never takes the spare value
    a_r4_mode_legal: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        speed_mode != 2'd3);

    // R9: codes hold while lock stays high
    a_r9_codes_hold: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        ($past(locked) && locked) |-> ($stable(ratio_code) && $stable(speed_mode)));

    // R9: lock rises only onto the classification already reported
    a_r9_rise_consistent: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        $rose(locked) |-> ($stable(ratio_code) && $stable(speed_mode)));
endmodule

// File: tb/tb_audio_rate_detect.sv
`timescale 1ns/1ps
module tb_audio_rate_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic [3:0] ratio_code;
    logic [1:0] speed_mode;
    logic       locked, ratio_err, unsupported;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int fr_ratio = 256;
    int ref_half = 80;
    int fc = 0;
    int prev_meas = 256;
    int prev_ratio = 256;

    audio_rate_detect #(
        .CNT_W(12), .REF_WINDOW(8), .TOL(2),
        .FRAMES_SD(2), .FRAMES_DQ(4), .MCLK_MAX(1500)
    ) dut (
        .clk_mclk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .ref_clk(ref_clk),
        .ratio_code(ratio_code), .speed_mode(speed_mode), .locked(locked),
        .ratio_err(ratio_err), .unsupported(unsupported));

    always #2.5 clk = ~clk;

    // Reference clock, offset so its edges never meet a master clock edge.
    initial begin
        #1;
        forever begin
            #(ref_half) ref_clk = ~ref_clk;
        end
    end

    // Frame clock derived from the master clock on its falling edge.
    always @(negedge clk) begin
        if (fc >= fr_ratio - 1) fc <= 0;
        else                    fc <= fc + 1;
        frame_clk <= (fc < fr_ratio / 2);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a frame ratio and absolute count, then wait until results settle.
    task automatic settle(input int ratio, input int meas);
        int wait_cyc;
        fr_ratio = ratio;
        ref_half = meas * 5 / 16;
        wait_cyc = prev_meas + 2 * meas + 5 * (ratio + prev_ratio) + 64;
        prev_meas = meas;
        prev_ratio = ratio;
        repeat (wait_cyc) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input int lk, input int idx,
                              input int md, input int er, input int un);
        chk({req, " locked"}, int'(locked), lk);
        chk({req, " ratio_err"}, int'(ratio_err), er);
        chk({req, " unsupported"}, int'(unsupported), un);
        if (idx >= 0) chk({req, " ratio_code"}, int'(ratio_code), idx);
        if (md >= 0)  chk({req, " speed_mode"}, int'(speed_mode), md);
    endtask

    task automatic t_reset;
        repeat (20) @(posedge clk);
        @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect_out("R1 after release", 0, 0, 0, 0, 0);
    endtask

    task automatic t_single256;   // R2 R4 R5 R9
        settle(256, 256);
        expect_out("R5 ratio 256 single", 1, 4, 0, 0, 0);
    endtask

    task automatic t_double256;   // R4 R5
        settle(256, 768);
        expect_out("R5 ratio 256 double", 1, 4, 1, 0, 0);
    endtask

    task automatic t_ratio128;    // R6
        settle(128, 384);
        expect_out("R6 ratio 128 double", 1, 2, 1, 0, 0);
        settle(128, 768);
        expect_out("R6 ratio 128 quad", 1, 2, 2, 0, 0);
    endtask

    task automatic t_quad64;      // R2 R4
        settle(64, 384);
        expect_out("R4 ratio 64 quad", 1, 0, 2, 0, 0);
    endtask

    task automatic t_tolerance;   // R2 R3
        settle(258, 256);
        expect_out("R2 period 258", 1, 4, 0, 0, 0);
        settle(254, 256);
        expect_out("R2 period 254", 1, 4, 0, 0, 0);
        settle(259, 256);
        expect_out("R3 period 259", 0, -1, -1, 1, 0);
        settle(300, 256);
        expect_out("R3 period 300", 0, -1, -1, 1, 0);
    endtask

    task automatic t_not_in_mode; // R7
        settle(64, 64);
        expect_out("R7 ratio 64 single", 0, 0, 0, 0, 1);
    endtask

    task automatic t_over_max;    // R8 R2
        settle(1152, 1152);
        expect_out("R2 ratio 1152 single", 1, 9, 0, 0, 0);
        settle(1152, 1728);
        expect_out("R8 over ceiling", 0, 9, 0, 0, 1);
    endtask

    task automatic t_drop;        // R10 R9
        bit fell;
        settle(256, 256);
        expect_out("R9 relock 256", 1, 4, 0, 0, 0);
        fr_ratio = 384;
        fell = 0;
        for (int i = 0; i < 3 * 384; i++) begin
            @(negedge clk);
            if (!locked) fell = 1;
        end
        chk("R10 lock drop on change", int'(fell), 1);
        settle(384, 256);
        expect_out("R9 relock 384", 1, 5, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_single256();
        t_double256();
        t_ratio128();
        t_quad64();
        t_tolerance();
        t_not_in_mode();
        t_over_max();
        t_drop();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #900000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule